// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 12-bit serial-input converter. A host sends 16-bit words over a three-wire link: a serial clock, a serial data line and an active-low frame sync. The block samples the link with a system clock and shifts each word into an input register. It then moves the word into the DAC latch that drives the converter core.

The latch is loaded in one of two ways, chosen by the level on the load input. If the load input is held low, the latch takes each complete word as soon as its last bit has been sampled. If the load input is held high, each complete word waits in a holding register, and a low pulse on the load input copies it into the latch. This lets several converters change their outputs together. Each latch load raises a one-cycle update pulse.

Top module: `serial_dac_front`

## Requirements
- R1: A frame carries 16 bits, most significant bit first. Bits [11:0] of the received word become the DAC code, and bits [15:12] have no effect on it.
- R2: A data bit is taken on the high-to-low transition of the serial clock. Data changes while the serial clock is low, before it rises again, do not affect the received word.
- R3: A high-to-low transition of the frame sync starts a new frame and clears the bit count, so a word sent after an aborted frame is received intact.
- R4: While the load input is low, the DAC latch takes the new word after its sixteenth falling serial clock edge and the update pulse fires once.
- R5: While the load input is high, a completed word does not change the DAC code. A later high-to-low transition of the load input copies the last complete word into the latch and fires the update pulse once.
- R6: If the frame sync returns high before 16 bits have arrived, the partial word is discarded. There is no update, and a later load pulse delivers the previous complete word.
- R7: Serial clock transitions while the frame sync is high shift nothing and cause no update.
- R8: A load pulse during a frame latches the last complete word, not the partially shifted bits.
- R9: After reset the DAC code is zero and the update pulse is low.
- R10: The update pulse lasts one system clock per latch load, and the DAC code changes only in a cycle where the update pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on the falling serial clock edge |
| frame_n | input | 1 | Active-low frame sync |
| load_n | input | 1 | Load strobe: held low for automatic update, pulsed low for a manual load |
| dac_code | output | 12 | Latched converter code |
| dac_upd | output | 1 | One-cycle pulse when the latch is loaded |

## Verification
The assertions assume that every level on the serial and load inputs lasts several system clocks, so the two-flop synchronizers see each transition exactly once. They also assume that no serial clock edge coincides with a frame sync edge, and that a load transition never lands in the same cycle as a word completion. The stimulus holds each serial clock phase for four system clocks and waits at least that long around frame sync and load changes. It changes data only while the serial clock is steady. The random frames draw word values, update mode and aborted frame lengths from a fixed seed.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned CODE_BITS = 12;
  localparam int unsigned CNT_W     = $clog2(WORD_BITS + 1);
  typedef logic [CODE_BITS-1:0] code_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned   W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST_VAL[i];
        stab_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d[i];
        stab_q[i] <= meta_q[i];
      end
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int unsigned NBITS = WORD_BITS,
  parameter int unsigned CBITS = CODE_BITS,
  parameter int unsigned CW    = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdat_s,
  input  logic             frame_n_s,
  output logic             word_ok,
  output logic [CBITS-1:0] word
);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);
  localparam logic [CW-1:0] FULL = CW'(NBITS);

  logic             sclk_q, frame_q;
  logic [NBITS-1:0] sr_q, sr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             done_d;
  logic [CBITS-1:0] word_d;
  logic             word_en;
  logic             sclk_fall, frame_fall;
  logic [NBITS-1:0] shifted;

  assign sclk_fall  = sclk_q & ~sclk_s;
  assign frame_fall = frame_q & ~frame_n_s;
  assign shifted    = {sr_q[NBITS-2:0], sdat_s};

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    word_en = 1'b0;
    word_d  = word;
    if (frame_fall) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (!frame_n_s && sclk_fall && (cnt_q < FULL)) begin
      sr_d  = shifted;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        done_d  = 1'b1;
        word_en = 1'b1;
        word_d  = shifted[CBITS-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
      sr_q    <= '0;
      cnt_q   <= '0;
      word_ok <= 1'b0;
      word    <= '0;
    end else begin
      sclk_q  <= sclk_s;
      frame_q <= frame_n_s;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      word_ok <= done_d;
      if (word_en) word <= word_d;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  assert_done_at_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok |-> cnt_q == FULL);
  assert_idle_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |=> ($stable(cnt_q) && !word_ok));
  assert_frame_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fall |=> cnt_q == '0);
  assert_partial_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n_s && cnt_q != FULL) |=> $stable(word));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int unsigned CBITS = CODE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n_s,
  input  logic             word_ok,
  input  logic [CBITS-1:0] word,
  output logic [CBITS-1:0] code,
  output logic             upd
);
  logic             load_q;
  logic             load_fall;
  logic             code_en;
  logic [CBITS-1:0] code_d;
  logic             upd_d;

  assign load_fall = load_q & ~load_n_s;

  always_comb begin
    code_en = 1'b0;
    upd_d   = 1'b0;
    code_d  = code;
    if (word_ok && !load_n_s) begin
      code_en = 1'b1;
      upd_d   = 1'b1;
      code_d  = word;
    end else if (load_fall) begin
      code_en = 1'b1;
      upd_d   = 1'b1;
      code_d  = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      code   <= '0;
      upd    <= 1'b0;
    end else begin
      load_q <= load_n_s;
      upd    <= upd_d;
      if (code_en) code <= code_d;
    end
  end

  assert_auto_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && !load_n_s) |=> (upd && code == $past(word)));
  assert_hold_in_pulse_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && load_n_s && load_q) |=> !upd);
  assert_code_only_on_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(code));
  assert_manual_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && !load_n_s && !word_ok) |=> (upd && code == $past(word)));
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import sdac_pkg::*;
#(
  parameter int unsigned NBITS = WORD_BITS,
  parameter int unsigned CBITS = CODE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             frame_n,
  input  logic             load_n,
  output logic [CBITS-1:0] dac_code,
  output logic             dac_upd
);
  localparam int unsigned NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

  logic [NSYNC-1:0] raw_in, syn;
  logic             word_ok;
  logic [CBITS-1:0] word;

  assign raw_in = {load_n, frame_n, ser_dat, ser_clk};

  sdac_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn)
  );

  sdac_shift #(.NBITS(NBITS), .CBITS(CBITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (syn[0]),
    .sdat_s    (syn[1]),
    .frame_n_s (syn[2]),
    .word_ok   (word_ok),
    .word      (word)
  );

  sdac_latch #(.CBITS(CBITS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n_s (syn[3]),
    .word_ok  (word_ok),
    .word     (word),
    .code     (dac_code),
    .upd      (dac_upd)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dac_upd && dac_code == '0));
endmodule

// File: tb/tb_serial_dac_front.sv
`timescale 1ns/1ps
module tb_serial_dac_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_dat, frame_n, load_n;
  logic [11:0] dac_code;
  logic        dac_upd;

  int checks = 0;
  int errors = 0;
  int upd_seen = 0;
  int dbl = 0;
  logic upd_prev = 1'b0;
  logic [11:0] last_word = '0;
  logic [11:0] exp_code  = '0;
  int exp_upd = 0;
  bit done = 1'b0;

  serial_dac_front dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .frame_n(frame_n), .load_n(load_n), .dac_code(dac_code), .dac_upd(dac_upd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (dac_upd) upd_seen++;
    if (dac_upd && upd_prev) dbl++;
    upd_prev <= dac_upd;
  end

  function automatic logic [11:0] code_of(input logic [15:0] w);
    return w[11:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the first nbits of w, MSB first; data is scrambled while sclk is low
  task automatic send_frame(input logic [15:0] w, input int nbits);
    frame_n = 1'b0;
    wait_clk(HALF_SCLK);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = w[15-i];
      wait_clk(HALF_SCLK);
      ser_clk = 1'b0;
      wait_clk(2);
      ser_dat = ~w[15-i];
      wait_clk(HALF_SCLK - 2);
      ser_clk = 1'b1;
    end
    wait_clk(HALF_SCLK);
    frame_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(HALF_SCLK);
    load_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic check_state(input string req);
    chk(dac_code == exp_code, req, dac_code, exp_code);
    chk(upd_seen == exp_upd, {req, " pulses"}, upd_seen, exp_upd);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    ser_clk = 1'b1; ser_dat = 1'b0; frame_n = 1'b1; load_n = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd2024));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R9 reset state
    chk(dac_code == 12'h000, "R9 code", dac_code, 0);
    chk(upd_seen == 0, "R9 upd", upd_seen, 0);

    // R1 R2 R4 auto mode, upper nibble ignored
    send_frame(16'hF5A3, 16);
    last_word = 12'h5A3; exp_code = 12'h5A3; exp_upd++;
    check_state("R1 R2 R4 auto");
    send_frame(16'h0C3E, 16);
    last_word = 12'hC3E; exp_code = 12'hC3E; exp_upd++;
    check_state("R4 auto second");

    // R7 clock toggles with frame high
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0];
      ser_clk = 1'b0; wait_clk(HALF_SCLK);
      ser_clk = 1'b1; wait_clk(HALF_SCLK);
    end
    wait_clk(6);
    check_state("R7 idle edges");

    // R6 R3 partial frame then full frame
    send_frame(16'hFFFF, 7);
    check_state("R6 partial auto");
    send_frame(16'h1234, 16);
    last_word = 12'h234; exp_code = 12'h234; exp_upd++;
    check_state("R3 after abort");

    // R5 manual mode
    load_n = 1'b1; wait_clk(8);
    check_state("R5 mode rise");
    send_frame(16'hA987, 16);
    last_word = 12'h987;
    check_state("R5 held");
    pulse_load();
    exp_code = 12'h987; exp_upd++;
    check_state("R5 load");

    // R8 load during frame
    frame_n = 1'b0; wait_clk(HALF_SCLK);
    w = 16'h4CDE;
    for (int i = 0; i < 8; i++) begin
      ser_dat = w[15-i]; wait_clk(HALF_SCLK);
      ser_clk = 1'b0; wait_clk(HALF_SCLK);
      ser_clk = 1'b1;
    end
    pulse_load();
    exp_upd++;
    check_state("R8 mid-frame load");
    for (int i = 8; i < 16; i++) begin
      ser_dat = w[15-i]; wait_clk(HALF_SCLK);
      ser_clk = 1'b0; wait_clk(HALF_SCLK);
      ser_clk = 1'b1;
    end
    wait_clk(HALF_SCLK); frame_n = 1'b1; wait_clk(8);
    last_word = 12'hCDE;
    check_state("R8 completion held");
    // R6 in manual mode: partial does not replace held word
    send_frame(16'h0111, 10);
    pulse_load();
    exp_code = 12'hCDE; exp_upd++;
    check_state("R6 partial manual");

    // random frames
    for (int it = 0; it < 40; it++) begin
      bit auto_m;
      int n;
      w = 16'($urandom);
      auto_m = 1'($urandom);
      n = ($urandom % 5 == 0) ? 1 + int'($urandom % 15) : 16;
      if (auto_m && load_n) begin
        load_n = 1'b0; wait_clk(8);
        exp_code = last_word; exp_upd++;
        check_state("R5 switch to auto");
      end else if (!auto_m && !load_n) begin
        load_n = 1'b1; wait_clk(8);
      end
      send_frame(w, n);
      if (n == 16) begin
        last_word = code_of(w);
        if (auto_m) begin exp_code = last_word; exp_upd++; end
      end
      check_state(n == 16 ? (auto_m ? "R4 rand" : "R5 rand held") : "R6 rand");
      if (!auto_m) begin
        pulse_load();
        exp_code = last_word; exp_upd++;
        check_state("R5 rand load");
      end
    end

    chk(dbl == 0, "R10 pulse width", dbl, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule